// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Generator

This block derives the bit clock of a synchronous serial port from the peripheral clock. Two divide stages run in cascade. The first is an even-only prescaler. The second is a post-divider that divides by one plus an 8-bit rate field. The resulting bit-clock frequency is the input frequency divided by the *product* of the two ratios. The output has a 50% duty cycle. Single-cycle rise and fall strobes, synchronous to the peripheral clock, go to the shift logic.

The prescaler also runs while the port is a slave. In that mode the bit clock stays at its idle level. The prescaler tick is still brought out as a sampling strobe, so slave operation always runs at a programmed rate.

The prescale value, rate field and mode are captured into internal holding registers at three times:
- while the block is disabled;
- at every cycle in slave mode;
- at the end of a full master bit period.

A change made in the middle of a period therefore cannot produce a short or stretched pulse.

Top module: `bitclk_gen`

## Requirements
- R1: During and right after a synchronous reset, `bitClk` is at the idle level (0 by default) and `riseStb`, `fallStb` and `sampleTick` are 0.
- R2: The effective prescale P takes `prescale` with bit 0 forced to 0. A result of 0 is treated as 2, so P is always an even value from 2 to 254. For example, prescale values 4 and 5 give the same timing, and 0 behaves like 2.
- R3: In master mode the bit-clock period is P × (1 + `rate`) input cycles. Each level lasts exactly half of that, H = (P/2) × (1 + `rate`) cycles.
- R4: When `enable` is first seen high at a clock edge (edge 1), `bitClk` leaves the idle level after edge H. It returns to idle after edge 2H and leaves it again after edge 3H.
- R5: `riseStb` is 1 for exactly the first cycle in which `bitClk` is 1 after a toggle. `fallStb` is 1 for exactly the first cycle in which `bitClk` is 0 after a toggle. The two are never 1 together.
- R6: One cycle after `enable` is seen low, `bitClk` is at the idle level, both counters are cleared and neither edge strobe is raised. Re-enabling restarts the timing of R4.
- R7: Changes to `prescale`, `rate` or `slaveMode` made while enabled in master mode take effect only when a full period ends, on the return to idle. The current period completes with the old values.
- R8: While `slaveMode` is in effect, `bitClk` stays at the idle level and neither edge strobe is raised.
- R9: While enabled, in either mode, `sampleTick` pulses for one cycle after every (P/2)-th edge counted from edge 1.
- R10: At the extremes with P = 2, `rate` = 255 gives a period of 512 cycles, and `rate` = 0 gives a period of 2 cycles, with `bitClk` toggling every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the dividers; low clears them and idles the bit clock |
| slaveMode | input | 1 | 1: prescaler only, bit clock held idle |
| prescale | input | 8 | Prescale value; bit 0 ignored, 0 read as 2 |
| rate | input | 8 | Post-divider field, divide by rate + 1 |
| bitClk | output | 1 | Generated bit clock |
| riseStb | output | 1 | One-cycle strobe with each rising bit-clock transition |
| fallStb | output | 1 | One-cycle strobe with each falling bit-clock transition |
| sampleTick | output | 1 | Prescaler tick, the sampling strobe in either mode |

## Verification
The bench builds the block with its default parameters: an 8-bit field width and idle level 0. With those values the real register widths are exercised, including both ends of each range:
- prescale values 0, 1, 2 and 254;
- rate values 0 and 255.

Random cases keep P and the rate small so that many of them fit in the run. Directed cases cover:
- a mid-period rate change;
- a disable in the high phase;
- slave-mode sampling.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;

  typedef struct packed {
    logic tick;    // prescaler terminal count this cycle
    logic toggle;  // bit clock flips at this edge
    logic clear;   // force idle, no edge strobes
  } bitclk_stb_t;

endpackage

// File: rtl/bitclk_ctrl.sv
module bitclk_ctrl
  import bitclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             slaveMode,
  input  logic [DIV_W-1:0] prescale,
  input  logic [DIV_W-1:0] rate,
  input  logic             atIdle,
  output bitclk_stb_t      stb
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] halfPreIn;
  logic [DIV_W-1:0] halfPreQ;
  logic [DIV_W-1:0] rateQ;
  logic             slaveQ;
  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] rateCnt;
  logic             tick;
  logic             lastTick;
  logic             toggle;
  logic             boundary;
  logic             load;

  // Half of the even prescale value; bit 0 dropped, zero floored to one.
  always_comb begin
    halfPreIn = {1'b0, prescale[DIV_W-1:1]};
    if (halfPreIn == '0) halfPreIn = ONE;
  end

  assign tick     = enable && (preCnt >= (halfPreQ - ONE));
  assign lastTick = (rateCnt >= rateQ);
  assign toggle   = tick && lastTick && !slaveQ;
  assign boundary = toggle && !atIdle;
  assign load     = !enable || slaveQ || boundary;

  // Configuration holding registers.
  always_ff @(posedge clk) begin
    if (rst || load) begin
      halfPreQ <= halfPreIn;
      rateQ    <= rate;
      slaveQ   <= slaveMode;
    end
  end

  // Prescaler counter.
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      preCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + ONE;
    end
  end

  // Post-divider counter, advanced by prescaler ticks.
  always_ff @(posedge clk) begin
    if (rst || !enable || slaveQ) begin
      rateCnt <= '0;
    end else if (tick) begin
      if (lastTick) rateCnt <= '0;
      else          rateCnt <= rateCnt + ONE;
    end
  end

  always_comb begin
    stb.tick   = tick;
    stb.toggle = toggle;
    stb.clear  = !enable || slaveQ;
  end

  // R2: the effective half prescale never reaches zero.
  a_r2_prescale_floor: assert property (@(posedge clk) disable iff (rst)
    halfPreQ != '0);

  // R3: with unchanged settings the prescaler never passes its terminal count.
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (rst)
    $past(enable) && $stable(halfPreQ) |-> preCnt < halfPreQ);

  // R8: in slave mode the post-divider stays cleared.
  a_r8_slave_rate_idle: assert property (@(posedge clk) disable iff (rst)
    $past(slaveQ) && $past(enable) |-> rateCnt == '0);

endmodule

// File: rtl/bitclk_dp.sv
module bitclk_dp
  import bitclk_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  bitclk_stb_t stb,
  output logic        bitClk,
  output logic        riseStb,
  output logic        fallStb,
  output logic        sampleTick,
  output logic        atIdle
);

  logic clkQ;

  always_ff @(posedge clk) begin
    if (rst || stb.clear) begin
      clkQ    <= IDLE_LEVEL;
      riseStb <= 1'b0;
      fallStb <= 1'b0;
    end else if (stb.toggle) begin
      clkQ    <= ~clkQ;
      riseStb <= ~clkQ;
      fallStb <= clkQ;
    end else begin
      riseStb <= 1'b0;
      fallStb <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sampleTick <= 1'b0;
    else     sampleTick <= stb.tick;
  end

  assign bitClk = clkQ;
  assign atIdle = (clkQ == IDLE_LEVEL);

  // R5: a rise strobe marks the first high cycle.
  a_r5_rise_marks_edge: assert property (@(posedge clk) disable iff (rst)
    riseStb |-> clkQ && !$past(clkQ));

  // R5: a fall strobe marks the first low cycle.
  a_r5_fall_marks_edge: assert property (@(posedge clk) disable iff (rst)
    fallStb |-> !clkQ && $past(clkQ));

  // R5: never both strobes at once.
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(riseStb && fallStb));

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
#(
  parameter int   DIV_W      = 8,
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             slaveMode,
  input  logic [DIV_W-1:0] prescale,
  input  logic [DIV_W-1:0] rate,
  output logic             bitClk,
  output logic             riseStb,
  output logic             fallStb,
  output logic             sampleTick
);

  bitclk_stb_t stb;
  logic        atIdle;

  bitclk_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .slaveMode (slaveMode),
    .prescale  (prescale),
    .rate      (rate),
    .atIdle    (atIdle),
    .stb       (stb)
  );

  bitclk_dp #(.IDLE_LEVEL(IDLE_LEVEL)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .bitClk     (bitClk),
    .riseStb    (riseStb),
    .fallStb    (fallStb),
    .sampleTick (sampleTick),
    .atIdle     (atIdle)
  );

  // R6: one cycle after enable is low the clock idles without strobes.
  a_r6_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (bitClk == IDLE_LEVEL) && !riseStb && !fallStb);

  // R1: outputs quiet the cycle after reset.
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (bitClk == IDLE_LEVEL) && !riseStb && !fallStb && !sampleTick);

endmodule

// File: tb/bitclk_gen_tb.sv
module bitclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic       slaveMode;
  logic [7:0] prescale;
  logic [7:0] rate;
  logic       bitClk, riseStb, fallStb, sampleTick;

  int  checks = 0;
  int  errors = 0;
  int  cyc;
  bit  prevClk;
  bit  stbOk;
  bit  done = 0;

  always #5 clk = ~clk;

  bitclk_gen u_dut (
    .clk(clk), .rst(rst), .enable(enable), .slaveMode(slaveMode),
    .prescale(prescale), .rate(rate), .bitClk(bitClk), .riseStb(riseStb),
    .fallStb(fallStb), .sampleTick(sampleTick)
  );

  function automatic int halfPre(input logic [7:0] p);
    int h = int'(p[7:1]);
    return (h == 0) ? 1 : h;
  endfunction

  function automatic int halfPeriod(input logic [7:0] p, input logic [7:0] r);
    return halfPre(p) * (int'(r) + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle forward; sample at the falling edge and check strobe agreement.
  task automatic step();
    @(negedge clk);
    cyc++;
    if (riseStb != (bitClk && !prevClk)) stbOk = 0;
    if (fallStb != (!bitClk && prevClk)) stbOk = 0;
    prevClk = bitClk;
  endtask

  task automatic startRun(input logic [7:0] p, input logic [7:0] r, input bit s);
    enable = 1'b0;
    slaveMode = s; prescale = p; rate = r;
    step(); step();
    enable = 1'b1;
    cyc = 0;
    stbOk = 1;
    prevClk = bitClk;
  endtask

  task automatic runMaster(input logic [7:0] p, input logic [7:0] r, input string tag);
    int hp = halfPeriod(p, r);
    int rise1 = -1, fall1 = -1, rise2 = -1, tick1 = -1;
    startRun(p, r, 1'b0);
    while (cyc < 3 * hp + 1) begin
      step();
      if (sampleTick && tick1 < 0) tick1 = cyc;
      if (riseStb && rise1 < 0) rise1 = cyc;
      else if (fallStb && fall1 < 0) fall1 = cyc;
      else if (riseStb && rise2 < 0) rise2 = cyc;
    end
    chk(rise1 == hp,     {tag, " R4 first rise"}, rise1, hp);
    chk(fall1 == 2 * hp, {tag, " R3 fall"}, fall1, 2 * hp);
    chk(rise2 == 3 * hp, {tag, " R3 period"}, rise2, 3 * hp);
    chk(tick1 == halfPre(p), {tag, " R9 sample tick"}, tick1, halfPre(p));
    chk(stbOk, {tag, " R5 strobes"}, int'(stbOk), 1);
    enable = 1'b0;
    step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    bit bad;
    rst = 1'b1; enable = 1'b0; slaveMode = 1'b0; prescale = 8'd2; rate = 8'd0;
    void'($urandom(32'h5eed_1234));
    cyc = 0; prevClk = 0; stbOk = 1;
    repeat (3) @(negedge clk);
    chk(!bitClk && !riseStb && !fallStb && !sampleTick, "R1 reset state",
        int'({bitClk, riseStb, fallStb, sampleTick}), 0);
    rst = 1'b0;
    step();
    chk(!bitClk && !sampleTick, "R1 after reset", int'({bitClk, sampleTick}), 0);

    // Directed corner cases
    runMaster(8'd2,   8'd0,   "R10 min");
    runMaster(8'd2,   8'd255, "R10 max rate");
    runMaster(8'd5,   8'd3,   "R2 odd prescale");
    runMaster(8'd0,   8'd4,   "R2 zero prescale");
    runMaster(8'd1,   8'd2,   "R2 one prescale");
    runMaster(8'd254, 8'd1,   "R2 max prescale");

    // Constrained random
    for (int i = 0; i < 12; i++) begin
      logic [7:0] p = 8'($urandom_range(0, 40));
      logic [7:0] r = 8'($urandom_range(0, 15));
      runMaster(p, r, "R3 random");
    end

    // R7: change rate during the high phase; P=4, rate 3 -> H=8, then rate 0 -> H=2
    startRun(8'd4, 8'd3, 1'b0);
    while (cyc < 10) step();
    rate = 8'd0;
    begin
      int f = -1, r2 = -1, f2 = -1;
      while (cyc < 24) begin
        step();
        if (fallStb && f < 0) f = cyc;
        else if (riseStb && r2 < 0) r2 = cyc;
        else if (fallStb && f2 < 0) f2 = cyc;
      end
      chk(f == 16,  "R7 old period completes", f, 16);
      chk(r2 == 18, "R7 new rate after boundary", r2, 18);
      chk(f2 == 20, "R7 new half period", f2, 20);
      chk(stbOk, "R7 R5 strobes", int'(stbOk), 1);
    end

    // R6: disable during the high phase (P=4 rate 3: high over cycles 8..15)
    startRun(8'd4, 8'd3, 1'b0);
    while (cyc < 10) step();
    chk(bitClk, "R6 high before disable", int'(bitClk), 1);
    enable = 1'b0;
    step();
    chk(!bitClk && !riseStb && !fallStb, "R6 idle after disable",
        int'({bitClk, riseStb, fallStb}), 0);
    repeat (3) step();
    chk(!bitClk, "R6 stays idle", int'(bitClk), 0);
    runMaster(8'd4, 8'd3, "R6 restart");

    // R8/R9: slave mode, P=6 -> tick every 3 cycles
    startRun(8'd6, 8'd0, 1'b1);
    cnt = 0; bad = 0;
    while (cyc < 30) begin
      step();
      if (sampleTick) begin
        cnt++;
        if (cyc % 3 != 0) bad = 1;
      end
      if (bitClk || riseStb || fallStb) bad = 1;
    end
    chk(cnt == 10, "R9 slave sample ticks", cnt, 10);
    chk(!bad, "R8 slave clock idle", int'(bad), 0);
    enable = 1'b0;
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule